// File: doc/BRIEF.md
# Run-Length Encoding Memory Co-Processor

This block compresses a byte message stored in a word-wide SRAM and writes the compressed stream back into the same memory. Software gives it a source byte address, a message length in bytes and a destination byte address, then pulses `start`. The block reads the message one 32-bit word at a time and unpacks the bytes little-endian. It walks them one byte per cycle and turns every run of equal bytes into a two-byte pair: a count byte followed by the symbol byte.

The pairs are repacked little-endian into 32-bit words and stored from the destination address upward. The block then reports the number of compressed bytes and raises `done`. The output can be longer than the input. When the message or the output does not fill its last word, the block handles the partial word itself.

The memory port follows the usual synchronous-SRAM rules. A read address presented with the write enable low returns data one clock later. A write presented with the write enable high completes at that clock edge. Only word-aligned addresses are used.

Top module: `rle_copro`

## Requirements
- R1: While `nreset` is low and after its release, `done` is 0, `mem_we` is 0 and `rle_size` is 0.
- R2: Message byte k is taken from word k/4 of the source area, bits [8*(k%4)+7 : 8*(k%4)]. The block reads a word by driving its address with `mem_we` low, and uses the data on `mem_rdata` one cycle later.
- R3: Each maximal run of equal bytes produces a count byte and then the symbol byte. Output byte j goes to word j/4 of the destination area, bits [8*(j%4)+7 : 8*(j%4)], so the count sits in the lower byte lane.
- R4: A run longer than 2^CNT_W-1 (255 by default) is split. A pair carrying the maximum count is emitted first, and counting restarts for the remaining equal bytes.
- R5: Bytes of the final source word beyond `message_size` have no effect on the output, even when they equal the last symbol.
- R6: When the output length is not a multiple of 4, the final partial word is still written, and its unused upper two bytes are zero.
- R7: `rle_size` reports the number of output bytes, which is twice the number of pairs.
- R8: `done` rises only after the last output write has completed. `done` and `rle_size` then stay unchanged until the next `start`.
- R9: A `message_size` of 0 gives `rle_size` 0 and `done` high, with no memory write.
- R10: The output occupies consecutive words from `rle_addr`, with exactly ceil(rle_size/4) writes. The word after the output area is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| nreset | input | 1 | Active-low reset |
| start | input | 1 | One-cycle request to begin a compression |
| message_addr | input | 32 | Byte address of the first source word |
| message_size | input | 32 | Message length in bytes |
| rle_addr | input | 32 | Byte address of the first destination word |
| rle_size | output | 32 | Compressed length in bytes |
| done | output | 1 | Compression finished, result valid |
| mem_addr | output | AW | Word-aligned byte address to the SRAM |
| mem_we | output | 1 | SRAM write enable |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, valid one cycle after the address |

## Verification
The bench builds the block with its defaults, AW=16 and CNT_W=8. With these values the real 255-count split is reachable using a 300-byte run, and a 4 KiB memory window holds both the source area and the destination area. The message lengths are chosen so that every input word fill (0 to 3 spare bytes) occurs. The output lengths are chosen to end on both half-word and full-word boundaries. The spare source bytes are set equal to the final symbol, so a wrongly extended run would change the result.

// File: rtl/rle_copro.sv
module rle_copro #(
  parameter int AW    = 16,
  parameter int CNT_W = 8
) (
  input  logic          clk,
  input  logic          nreset,
  input  logic          start,
  input  logic [31:0]   message_addr,
  input  logic [31:0]   message_size,
  input  logic [31:0]   rle_addr,
  output logic [31:0]   rle_size,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);

  localparam logic [CNT_W-1:0] MAX_RUN = '1;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_LOAD, S_BYTE, S_FIN, S_WRITE, S_DONE} st_t;

  st_t             state, ret, after;
  logic [AW-1:0]   rd_ptr, wr_ptr;
  logic [31:0]     left, word, obuf;
  logic [1:0]      bidx;
  logic            half, have;
  logic [7:0]      sym;
  logic [CNT_W-1:0] cnt;
  logic            unused_hi;

  assign unused_hi = ^{message_addr[31:AW], rle_addr[31:AW]};

  wire [7:0] cur    = word[{bidx, 3'b000} +: 8];
  wire [7:0] cnt_b  = 8'(cnt);
  wire       extend = have && (cur == sym) && (cnt != MAX_RUN);
  wire       emit   = (state == S_BYTE) && have && !extend;
  wire       last   = (left == 32'd1);

  always_comb after = last ? S_FIN : ((bidx == 2'd3) ? S_READ : S_BYTE);

  function automatic logic [31:0] put(input logic [31:0] b, input logic h,
                                      input logic [7:0] c, input logic [7:0] s);
    put = h ? {s, c, b[15:0]} : {16'h0, s, c};
  endfunction

  always_ff @(posedge clk or negedge nreset) begin
    if (!nreset) begin
      state    <= S_IDLE;
      ret      <= S_IDLE;
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      left     <= '0;
      word     <= '0;
      obuf     <= '0;
      bidx     <= '0;
      half     <= 1'b0;
      have     <= 1'b0;
      sym      <= '0;
      cnt      <= '0;
      rle_size <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          rd_ptr   <= message_addr[AW-1:0];
          wr_ptr   <= rle_addr[AW-1:0];
          left     <= message_size;
          rle_size <= '0;
          half     <= 1'b0;
          have     <= 1'b0;
          obuf     <= '0;
          state    <= (message_size == 32'd0) ? S_DONE : S_READ;
        end
        S_READ: state <= S_LOAD;
        S_LOAD: begin
          word   <= mem_rdata;
          bidx   <= '0;
          rd_ptr <= rd_ptr + AW'(4);
          state  <= S_BYTE;
        end
        S_BYTE: begin
          left <= left - 32'd1;
          bidx <= bidx + 2'd1;
          if (extend) cnt <= cnt + 1'b1;
          else begin
            sym  <= cur;
            cnt  <= CNT_W'(1);
            have <= 1'b1;
          end
          if (emit) begin
            obuf     <= put(obuf, half, cnt_b, sym);
            half     <= ~half;
            rle_size <= rle_size + 32'd2;
          end
          if (emit && half) begin
            state <= S_WRITE;
            ret   <= after;
          end else begin
            state <= after;
          end
        end
        S_FIN: begin
          obuf     <= put(obuf, half, cnt_b, sym);
          half     <= ~half;
          rle_size <= rle_size + 32'd2;
          state    <= S_WRITE;
          ret      <= S_DONE;
        end
        S_WRITE: begin
          wr_ptr <= wr_ptr + AW'(4);
          state  <= ret;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done      = (state == S_DONE);
  assign mem_we    = (state == S_WRITE);
  assign mem_addr  = (state == S_WRITE) ? wr_ptr : rd_ptr;
  assign mem_wdata = obuf;

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!nreset)
    (done && !start) |=> done);                                   // R8
  AST_SIZE_FROZEN: assert property (@(posedge clk) disable iff (!nreset)
    (done && !start) |=> $stable(rle_size));                      // R8
  AST_SIZE_EVEN: assert property (@(posedge clk) disable iff (!nreset)
    done |-> !rle_size[0]);                                       // R7
  AST_FINAL_RUN_LIVE: assert property (@(posedge clk) disable iff (!nreset)
    (state == S_FIN) |-> (have && cnt != '0));                    // R3
  AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (!nreset)
    (done && rle_size == 32'd0) |-> !$past(mem_we));              // R9
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!nreset)
    mem_we |=> !mem_we);                                          // R10

endmodule

// File: tb/sim_rle_copro.sv
module sim_rle_copro;
  localparam int CLK_P = 10;
  localparam int SRC = 32'h100;
  localparam int DST = 32'h800;

  logic        clk = 1'b0;
  logic        nreset = 1'b0;
  logic        start = 1'b0;
  logic [31:0] message_addr = SRC, message_size = '0, rle_addr = DST;
  logic [31:0] rle_size, mem_wdata, mem_rdata;
  logic        done, mem_we;
  logic [15:0] mem_addr;

  logic [31:0] mem [0:1023];
  logic [7:0]  msg [0:1023];
  logic [7:0]  ex  [0:2047];
  int ex_n, wr_count;
  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  rle_copro u0 (.clk(clk), .nreset(nreset), .start(start), .message_addr(message_addr),
    .message_size(message_size), .rle_addr(rle_addr), .rle_size(rle_size), .done(done),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[11:2]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    mem_rdata <= mem[mem_addr[11:2]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input int n);
    int i = 0;
    ex_n = 0;
    while (i < n) begin
      int c = 1;
      while (i + c < n && msg[i+c] == msg[i] && c < 255) c++;
      ex[ex_n] = 8'(c); ex[ex_n+1] = msg[i];
      ex_n += 2;
      i += c;
    end
  endtask

  task automatic run_case(input int n, input string req);
    logic [31:0] held;
    int nw;
    model(n);
    for (int w = 0; w < 1024; w++) mem[w] = 32'hDEADBEEF;
    for (int k = 0; k < ((n + 3) / 4) * 4; k++)
      mem[SRC/4 + k/4][8*(k%4) +: 8] = (k < n) ? msg[k] : msg[n-1];   // R5 spare = last symbol
    @(negedge clk);
    wr_count = 0;
    message_size = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 5000 && !done; t++) @(negedge clk);
    chk(done, {req, " R8 done reached"}, {31'd0, done}, 1);
    chk(rle_size == ex_n, {req, " R7 rle_size"}, rle_size, ex_n);
    nw = (ex_n + 3) / 4;
    chk(wr_count == nw, {req, " R10 write count"}, wr_count, nw);
    for (int w = 0; w < nw; w++) begin
      logic [31:0] e = '0;
      for (int b = 0; b < 4; b++) if (4*w + b < ex_n) e[8*b +: 8] = ex[4*w + b];
      chk(mem[DST/4 + w] == e, {req, " R3 R6 output word"}, mem[DST/4 + w], e);
    end
    chk(mem[DST/4 + nw] == 32'hDEADBEEF, {req, " R10 word past output"}, mem[DST/4 + nw], 32'hDEADBEEF);
    held = rle_size;
    repeat (4) @(negedge clk);
    chk(done && rle_size == held, {req, " R8 hold"}, rle_size, held);
  endtask

  task automatic t_reset;
    chk(!done && !mem_we && rle_size == 0, "R1 reset", {done, mem_we, rle_size[29:0]}, 0);
  endtask

  task automatic t_abc;
    for (int i = 0; i < 12; i++) msg[i] = 8'h41 + 8'(i % 3);
    run_case(12, "R2 R3 abc");
  endtask

  task automatic t_mixed;
    for (int i = 0; i < 48; i++) msg[i] = 8'h30 + 8'((i * i) >> 6);
    run_case(48, "R2 mixed");
  endtask

  task automatic t_odd;
    for (int i = 0; i < 51; i++) msg[i] = (i < 40) ? 8'h61 + 8'(i / 6) : 8'h7A;
    run_case(51, "R5 odd51");
    for (int i = 0; i < 49; i++) msg[i] = 8'h50 + 8'(i / 10);
    run_case(49, "R5 odd49");
  endtask

  task automatic t_long;
    for (int i = 0; i < 302; i++) msg[i] = (i < 300) ? 8'h5A : 8'h51;
    run_case(302, "R4 long");
  endtask

  task automatic t_one;
    msg[0] = 8'h58;
    run_case(1, "R6 single");
  endtask

  task automatic t_empty;
    msg[0] = 8'h11;
    run_case(0, "R9 empty");
    chk(wr_count == 0, "R9 no writes", wr_count, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    nreset = 1'b1;
    @(negedge clk);
    t_reset;
    t_abc;
    t_mixed;
    t_odd;
    t_long;
    t_one;
    t_empty;
    t_abc;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule